// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block conditions a small set of dedicated external interrupt inputs. Each input has an enable bit and a two-bit sense mode. The mode picks one of three triggers: low level, falling edge or rising edge. Edge triggers go through a synchronizer clocked by the I/O clock. A detected edge sets a sticky flag that software clears by writing one. A level trigger sets no flag. Its request follows the raw pin directly, with no clock in the path, and stays asserted for as long as the pin is held low.

The `halt_i` input says that the I/O clock is stopped for a deep sleep state. While it is high, the block discards edge events. A low level on an input that is enabled in level mode still raises `wake_o`. The trigger applies whatever drives the pin, so software that drives the pin itself can raise an interrupt. A level that goes away before the system has woken leaves nothing recorded. The per-input requests are ORed into a single `irq_o`.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset every flag is 0. With all pins high, `req_o` and `irq_o` are 0.
- R2: Mode 2'b10 (falling edge), with the input enabled: a 1-to-0 transition on the pin sets the input's flag by the third rising clock edge after the change.
- R3: Mode 2'b11 (rising edge), with the input enabled: a 0-to-1 transition on the pin sets the input's flag by the third rising clock edge after the change.
- R4: In an edge mode, a transition in the opposite direction does not set the flag.
- R5: Mode 2'b01 is reserved. It never sets a flag and never raises a request.
- R6: Mode 2'b00 (low level), with the input enabled: `req_o[i]` is high, with no clock needed, for exactly as long as the pin is low. It never sets a flag.
- R7: A disabled input sets no flag and raises no request, whatever its mode and pin activity.
- R8: Writing 1 to `clr_i[i]` clears flag i on the next clock edge when no new event arrives for it.
- R9: When a new edge event and a clear for the same input fall in the same cycle, the flag ends up set.
- R10: Edge transitions that happen while `halt_i` is high are discarded, and no flag is set for them after `halt_i` falls.
- R11: `wake_o` is high when `halt_i` is high and at least one enabled level-mode input has its pin low. It does not depend on the clock.
- R12: `req_o[i]` is the enable bit ANDed with (flag or active level). `irq_o` is the OR of all `req_o` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | N_IRQ | Raw external interrupt pins |
| en_i | input | N_IRQ | Per-input enable |
| mode_i | input | 2*N_IRQ | Per-input sense mode, input i at bits [2i+1:2i] |
| halt_i | input | 1 | I/O clock halted (deep sleep) |
| clr_i | input | N_IRQ | Write-one-to-clear strobes for the flags |
| flag_o | output | N_IRQ | Sticky edge flags |
| req_o | output | N_IRQ | Per-input interrupt requests |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Asynchronous wake request |

## Verification
Every input is swept through all four mode codes, with the enable on and off, under both a rising and a falling pin transition. This separates the two edge modes from each other, from the reserved code and from level mode, and it shows that a disabled input does nothing. Level mode is checked with the pin held low and then released, which shows that its request follows the pin and leaves no trace. Three further sequences are run. A clear without an event shows the clear working. A clear that lands in the same cycle as a new edge shows which one wins. A transition during halt, together with a level pin low, shows that edges are suppressed while the wake path still works.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eis_chan.sv
module eis_chan
  import ext_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pin_i,      // raw pin, level path
  input  logic   pin_sync_i, // synchronized pin, edge path
  input  logic   en_i,
  input  sense_e mode_i,
  input  logic   edge_ok_i,  // low while clock is halted or resettling
  input  logic   clr_i,
  output logic   flag_o,
  output logic   req_o,
  output logic   lvl_o
);
  logic prev_q, flag_q, set;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= pin_sync_i;
  end

  assign rise = pin_sync_i & ~prev_q;
  assign fall = ~pin_sync_i & prev_q;

  always_comb begin
    set = 1'b0;
    if (en_i && edge_ok_i) begin
      unique case (mode_i)
        SENSE_FALL: set = fall;
        SENSE_RISE: set = rise;
        default:    set = 1'b0;
      endcase
    end
  end

  // new event beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set | (flag_q & ~clr_i);
  end

  assign lvl_o  = en_i & (mode_i == SENSE_LOW) & ~pin_i;
  assign flag_o = flag_q;
  assign req_o  = en_i & (flag_q | lvl_o);

  a_r6_level_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_LOW) |=> !$rose(flag_q));
  a_r5_rsvd_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_RSVD) |=> !$rose(flag_q));
  a_r7_disabled_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !$rose(flag_q));
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set) |=> !flag_q);
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set |=> flag_q);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_IRQ       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_IRQ-1:0]   pin_i,
  input  logic [N_IRQ-1:0]   en_i,
  input  logic [2*N_IRQ-1:0] mode_i,
  input  logic               halt_i,
  input  logic [N_IRQ-1:0]   clr_i,
  output logic [N_IRQ-1:0]   flag_o,
  output logic [N_IRQ-1:0]   req_o,
  output logic               irq_o,
  output logic               wake_o
);
  localparam int unsigned CW = $clog2(SYNC_STAGES + 1);

  logic [CW-1:0]    settle_q;
  logic             edge_ok;
  logic [N_IRQ-1:0] pin_sync, lvl;

  // edges in flight when the clock stops are dropped until the chain refills
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              settle_q <= '0;
    else if (halt_i)          settle_q <= CW'(SYNC_STAGES);
    else if (settle_q != '0)  settle_q <= settle_q - CW'(1);
  end

  assign edge_ok = !halt_i && (settle_q == '0);

  for (genvar g = 0; g < N_IRQ; g++) begin : g_ch
    eis_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_i[g]),
      .q_o    (pin_sync[g])
    );
    eis_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pin_i[g]),
      .pin_sync_i (pin_sync[g]),
      .en_i       (en_i[g]),
      .mode_i     (sense_e'(mode_i[2*g +: 2])),
      .edge_ok_i  (edge_ok),
      .clr_i      (clr_i[g]),
      .flag_o     (flag_o[g]),
      .req_o      (req_o[g]),
      .lvl_o      (lvl[g])
    );
  end

  assign irq_o  = |req_o;
  assign wake_o = halt_i & (|lvl);

  a_r10_halt_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> ((flag_o & ~$past(flag_o)) == '0));
  a_r11_wake_implies_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> irq_o);
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |=> (flag_o == '0));
endmodule

// File: tb/ext_irq_sense_tb.sv
`timescale 1ns/1ps
module ext_irq_sense_tb;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   pin = '1;
  logic [N-1:0]   en = '0;
  logic [2*N-1:0] mode = '0;
  logic           halt = 1'b0;
  logic [N-1:0]   clr = '0;
  logic [N-1:0]   flag, req;
  logic           irq, wake;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_sense #(.N_IRQ(N), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .en_i(en), .mode_i(mode),
    .halt_i(halt), .clr_i(clr), .flag_o(flag), .req_o(req),
    .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr = '1; tick(1); clr = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 flag", flag, 0);
    chk("R1 req", req, 0);
    chk("R1 irq", irq, 0);

    // sweep: input x mode x enable x direction (R2 R3 R4 R5 R6 R7 R12)
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 4; m++) begin
        for (int e = 0; e < 2; e++) begin
          for (int d = 0; d < 2; d++) begin
            logic start_lvl, exp_f, exp_r;
            start_lvl = (d == 0);   // d=0 falling, d=1 rising
            en = '0; en[i] = e[0];
            mode = '0; mode[2*i +: 2] = m[1:0];
            pin = '1; pin[i] = start_lvl;
            tick(4);
            clear_all();
            tick(1);
            pin[i] = ~start_lvl;
            tick(4);
            exp_f = e[0] && ((m == 2 && d == 0) || (m == 3 && d == 1));
            exp_r = e[0] && (exp_f || (m == 0 && pin[i] == 1'b0));
            chk($sformatf("R2_R3_R4_R5_R7 flag i%0d m%0d e%0d d%0d", i, m, e, d), flag, {28'd0, exp_f} << i);
            chk($sformatf("R6_R12 req i%0d m%0d e%0d d%0d", i, m, e, d), req, {28'd0, exp_r} << i);
            chk($sformatf("R12 irq i%0d m%0d e%0d d%0d", i, m, e, d), irq, exp_r);
          end
        end
      end
    end

    // R6 level follows pin without clock edges
    en = 4'b0010; mode = '0; pin = '1; clear_all(); tick(1);
    pin[1] = 1'b0; #1;
    chk("R6 level req immediate", req, 4'b0010);
    pin[1] = 1'b1; #1;
    chk("R6 level release", req, 0);
    chk("R6 no flag", flag, 0);

    // R8 / R9 on input 0, falling mode
    en = 4'b0001; mode = 8'b0000_0010; pin = '1; tick(4); clear_all();
    pin[0] = 1'b0; tick(4);
    chk("R2 flag set", flag, 4'b0001);
    pin[0] = 1'b1; tick(4);
    chk("R4 rise keeps flag", flag, 4'b0001);
    pin[0] = 1'b0; tick(2);
    clr[0] = 1'b1; tick(1); clr[0] = 1'b0;
    chk("R9 set wins over clear", flag, 4'b0001);
    clr[0] = 1'b1; tick(1); clr[0] = 1'b0;
    chk("R8 clear", flag, 0);
    chk("R8 req after clear", req, 0);

    // R10 / R11 halt behaviour
    pin = '1; en = 4'b0011; mode = 8'b0000_0010; tick(4); clear_all();
    halt = 1'b1;
    pin[0] = 1'b0; tick(4);
    #1 chk("R11 no wake without level", wake, 0);
    pin[1] = 1'b0; #1;
    chk("R11 wake on level in halt", wake, 1'b1);
    chk("R12 irq with level", irq, 1'b1);
    pin[1] = 1'b1; #1;
    chk("R11 wake drops with level", wake, 0);
    tick(1);
    halt = 1'b0; tick(6);
    chk("R10 no flag after halt", flag, 0);
    pin[1] = 1'b0; #1;
    chk("R11 no wake when running", wake, 0);
    pin[1] = 1'b1;
    pin[0] = 1'b1; tick(4);
    pin[0] = 1'b0; tick(4);
    chk("R10 edges resume after halt", flag, 4'b0001);

    done = 1'b1;
    summary();
  end
endmodule